// File: doc/BRIEF.md
# Staged clock-source select controller

This block is the register side of a bank of clock-source multiplexers. For each channel it holds a parent-select index and a gate bit. It drives the index and the gate to the clock-switching cells beside it. Software reaches the block through a simple write port and a registered read port. Each channel is built in one of two modes, fixed by a parameter.

An atomic channel has three write-only style registers: a set register, a clear register and an update register. A select index is first staged in a shadow register, by a clear write followed by a set write. If the channel has an update bit, the staged index reaches the select output only when a one is written to that bit. A channel without an update bit lets set and clear writes reach the output directly. The gate bit means "clock stopped" when it is 1: writing it through the clear register starts the clock, and writing it through the set register stops it.

A legacy channel has one combined register that holds the index and the gate bit. Software updates it by read-modify-write. In both modes, an index at or beyond the channel's parent count is refused, and the refusal is recorded in a sticky per-channel error flag.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset every select output is 0, every gate output is 1 (clock stopped), every error flag is 0, and reading an atomic channel's set register returns 4'h8.
- R2: A write to an atomic channel's set register (address = channel*4 + 0) ORs data bits [2:0] into the shadow index. If data bit 3 is 1, the write stops the gate (gate output 1).
- R3: A write to an atomic channel's clear register (offset 1) clears the shadow-index bits where data bits [2:0] are 1. If data bit 3 is 1, the write starts the gate (gate output 0).
- R4: On a channel with an update bit, set and clear writes leave the select output unchanged. A write to the update register (offset 2) with data bit 0 = 1 copies the shadow index to the select output on the clock edge that takes the write.
- R5: On an atomic channel without an update bit, the select output takes the new shadow index on the same edge as a set or clear write.
- R6: On a legacy channel, a write to the combined register (offset 3) loads data bits [2:0] as the select output and data bit 3 as the gate output. Both take effect on the edge that takes the write.
- R7: A set write whose resulting index would be at or above the channel's parent count is ignored entirely, gate included. The same holds for a legacy write carrying such an index. Either one sets that channel's error flag, and only reset clears the flag.
- R8: Read data appears one cycle after the address is presented. Set and clear offsets return {gate, shadow index}, the update offset returns 0, and a legacy channel's offset 3 returns {gate, select output}.
- R9: Writes to offsets that a channel's mode does not implement have no effect, and reads of those offsets return 0. This covers offset 3 of an atomic channel and offsets 0 to 2 of a legacy channel. An update write with data bit 0 = 0 also has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Channel in bits [3:2], register offset in bits [1:0]; also the read address |
| bus_wdata | input | 4 | Write data: index in [2:0], gate in [3] |
| bus_rdata | output | 4 | Registered read data for the previous cycle's address |
| sel_o | output | 12 | Select index per channel, channel i in bits [3i+2:3i] |
| gate_off_o | output | 4 | Per-channel gate, 1 = clock stopped |
| err_o | output | 4 | Per-channel sticky out-of-range flag |

## Verification
The bench uses the default build of four channels. Channel 0 is atomic with an update bit and six parents. Channel 1 is atomic with an update bit and eight parents, so the largest index 7 is legal. Channel 2 is atomic with no update bit and three parents, so an OR that lands on 3 is refused. Channel 3 is legacy with five parents. Together these reach staged and direct select paths, the refusal boundary just above the last parent, and cross-mode writes and reads at offsets that a channel does not implement.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic [1:0] {
    OFF_SET = 2'd0,
    OFF_CLR = 2'd1,
    OFF_UPD = 2'd2,
    OFF_LEG = 2'd3
  } reg_off_e;
endpackage

// File: rtl/clksel_chan.sv
module clksel_chan
  import clksel_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int NPAR    = 6,
  parameter bit ATOMIC  = 1'b1,
  parameter bit HAS_UPD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_off,
  input  logic [SEL_W-1:0] wsel,
  input  logic             wgate,
  input  logic [1:0]       rd_off,
  output logic [SEL_W-1:0] sel_o,
  output logic             gate_off_o,
  output logic             err_o,
  output logic [SEL_W:0]   rd_word
);
  localparam logic [SEL_W:0] NPAR_L = NPAR[SEL_W:0];

  logic [SEL_W-1:0] shad_q, act_q;
  logic             gate_q, err_q;
  logic [SEL_W-1:0] set_val, clr_val;
  logic             set_bad, leg_bad, upd_pulse, wr_set, wr_clr, wr_leg;

  always_comb begin
    set_val   = shad_q | wsel;
    clr_val   = shad_q & ~wsel;
    set_bad   = ({1'b0, set_val} >= NPAR_L);
    leg_bad   = ({1'b0, wsel} >= NPAR_L);
    wr_set    = ATOMIC && wr_en && (wr_off == OFF_SET);
    wr_clr    = ATOMIC && wr_en && (wr_off == OFF_CLR);
    wr_leg    = !ATOMIC && wr_en && (wr_off == OFF_LEG);
    upd_pulse = ATOMIC && HAS_UPD && wr_en && (wr_off == OFF_UPD) && wsel[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shad_q <= '0;
      act_q  <= '0;
      gate_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      if (wr_set) begin
        if (set_bad) begin
          err_q <= 1'b1;
        end else begin
          shad_q <= set_val;
          if (wgate) gate_q <= 1'b1;
          if (!HAS_UPD) act_q <= set_val;
        end
      end
      if (wr_clr) begin
        shad_q <= clr_val;
        if (wgate) gate_q <= 1'b0;
        if (!HAS_UPD) act_q <= clr_val;
      end
      if (upd_pulse) act_q <= shad_q;
      if (wr_leg) begin
        if (leg_bad) begin
          err_q <= 1'b1;
        end else begin
          shad_q <= wsel;
          act_q  <= wsel;
          gate_q <= wgate;
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (ATOMIC) begin
      if (rd_off == OFF_SET || rd_off == OFF_CLR) rd_word = {gate_q, shad_q};
    end else begin
      if (rd_off == OFF_LEG) rd_word = {gate_q, act_q};
    end
  end

  assign sel_o      = act_q;
  assign gate_off_o = gate_q;
  assign err_o      = err_q;

  p_sel_range_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ({1'b0, sel_o} < NPAR_L));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  p_bad_set_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_set && set_bad) |=> ($stable(shad_q) && $stable(gate_off_o) && err_o));

  generate
    if (ATOMIC && HAS_UPD) begin : g_upd_chk
      p_upd_load_r4: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> (sel_o == $past(shad_q)));
      p_sel_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !upd_pulse |=> $stable(sel_o));
    end
    if (ATOMIC && !HAS_UPD) begin : g_direct_chk
      p_direct_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sel_o == shad_q));
    end
  endgenerate
endmodule

// File: rtl/clksel_rdback.sv
module clksel_rdback #(
  parameter int NCH    = 4,
  parameter int DATA_W = 4,
  parameter int CH_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH*DATA_W-1:0] words,
  input  logic [CH_W-1:0]       rd_ch,
  output logic [DATA_W-1:0]     rdata_o
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ch == CH_W'(i)) pick = words[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= pick;
  end
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int               NCH         = 4,
  parameter int               SEL_W       = 3,
  parameter logic [NCH-1:0]   ATOMIC_MASK = 4'b0111,
  parameter logic [NCH-1:0]   UPD_MASK    = 4'b0011,
  parameter logic [NCH*(SEL_W+1)-1:0] PAR_CNT = {4'd5, 4'd3, 4'd8, 4'd6},
  localparam int DATA_W = SEL_W + 1,
  localparam int CNT_W  = SEL_W + 1,
  localparam int CH_W   = $clog2(NCH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NCH*SEL_W-1:0] sel_o,
  output logic [NCH-1:0]       gate_off_o,
  output logic [NCH-1:0]       err_o
);
  logic [CH_W-1:0]       acc_ch;
  logic [1:0]            acc_off;
  logic [NCH*DATA_W-1:0] words;

  assign acc_ch  = bus_addr[ADDR_W-1:2];
  assign acc_off = bus_addr[1:0];

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int NP = int'(PAR_CNT[i*CNT_W +: CNT_W]);
      clksel_chan #(
        .SEL_W  (SEL_W),
        .NPAR   (NP),
        .ATOMIC (ATOMIC_MASK[i]),
        .HAS_UPD(UPD_MASK[i])
      ) u_chan (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr && (acc_ch == CH_W'(i))),
        .wr_off    (acc_off),
        .wsel      (bus_wdata[SEL_W-1:0]),
        .wgate     (bus_wdata[SEL_W]),
        .rd_off    (acc_off),
        .sel_o     (sel_o[i*SEL_W +: SEL_W]),
        .gate_off_o(gate_off_o[i]),
        .err_o     (err_o[i]),
        .rd_word   (words[i*DATA_W +: DATA_W])
      );
    end
  endgenerate

  clksel_rdback #(.NCH(NCH), .DATA_W(DATA_W), .CH_W(CH_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .words  (words),
    .rd_ch  (acc_ch),
    .rdata_o(bus_rdata)
  );

  p_upd_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_off == OFF_UPD) |=> (bus_rdata == '0));
endmodule

// File: tb/clksel_ctrl_tb_top.sv
module clksel_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [3:0]  bus_wdata;
  logic [3:0]  bus_rdata;
  logic [11:0] sel_o;
  logic [3:0]  gate_off_o;
  logic [3:0]  err_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clksel_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_o(sel_o),
    .gate_off_o(gate_off_o), .err_o(err_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sel_of(input int ch);
    return int'(sel_o[ch*3 +: 3]);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input int exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check(tag, int'(bus_rdata), exp);
  endtask

  task automatic t_reset();
    check("R1 sel after reset", int'(sel_o), 0);
    check("R1 gate after reset", int'(gate_off_o), 4'hF);
    check("R1 err after reset", int'(err_o), 0);
    rd_chk(4'h0, 4'h8, "R1 set reg read after reset");
  endtask

  task automatic t_stage();
    wr(4'h0, 4'h3);
    rd_chk(4'h0, 4'hB, "R2 set staged into shadow");
    rd_chk(4'h1, 4'hB, "R8 clear offset reads shadow");
    check("R2 gate stopped by set", int'(gate_off_o[0]), 1);
    check("R4 select held before update", sel_of(0), 0);
  endtask

  task automatic t_update();
    wr(4'h2, 4'h0);
    check("R9 update with bit0=0 ignored", sel_of(0), 0);
    wr(4'h2, 4'h1);
    check("R4 update loads select", sel_of(0), 3);
    rd_chk(4'h2, 0, "R8 update offset reads zero");
  endtask

  task automatic t_clear();
    wr(4'h1, 4'h9);
    check("R3 gate started by clear", int'(gate_off_o[0]), 0);
    check("R4 clear does not move select", sel_of(0), 3);
    rd_chk(4'h0, 4'h2, "R3 clear bits in shadow");
    wr(4'h2, 4'h1);
    check("R4 update after clear", sel_of(0), 2);
  endtask

  task automatic t_range();
    wr(4'h0, 4'hC);
    check("R7 err raised on ch0", int'(err_o[0]), 1);
    check("R7 gate untouched by refused set", int'(gate_off_o[0]), 0);
    rd_chk(4'h0, 4'h2, "R7 shadow untouched by refused set");
    wr(4'h0, 4'h1);
    rd_chk(4'h0, 4'h3, "R2 set after refusal");
    check("R7 err stays sticky", int'(err_o[0]), 1);
    wr(4'h4, 4'hF);
    check("R7 top legal index no err", int'(err_o[1]), 0);
    wr(4'h6, 4'h1);
    check("R4 ch1 largest index", sel_of(1), 7);
  endtask

  task automatic t_direct();
    wr(4'h8, 4'h2);
    check("R5 direct set", sel_of(2), 2);
    wr(4'h9, 4'h2);
    check("R5 direct clear", sel_of(2), 0);
    wr(4'h8, 4'h3);
    check("R7 ch2 refused at count", int'(err_o[2]), 1);
    check("R7 ch2 select kept", sel_of(2), 0);
    wr(4'hA, 4'h1);
    check("R9 update on no-update channel", sel_of(2), 0);
  endtask

  task automatic t_legacy();
    wr(4'hF, 4'h4);
    check("R6 legacy select", sel_of(3), 4);
    check("R6 legacy gate", int'(gate_off_o[3]), 0);
    rd_chk(4'hF, 4'h4, "R6 legacy readback");
    wr(4'hF, 4'hD);
    check("R7 legacy refused err", int'(err_o[3]), 1);
    check("R7 legacy select kept", sel_of(3), 4);
    wr(4'hF, 4'hB);
    check("R6 legacy second write", sel_of(3), 3);
    rd_chk(4'hF, 4'hB, "R6 legacy readback gate");
  endtask

  task automatic t_isolate();
    wr(4'h3, 4'h5);
    check("R9 legacy offset on atomic ch", sel_of(0), 2);
    rd_chk(4'h3, 0, "R9 atomic ch offset3 reads zero");
    rd_chk(4'h0, 4'h3, "R9 atomic shadow untouched");
    wr(4'hC, 4'h1);
    check("R9 set on legacy ch", sel_of(3), 3);
    rd_chk(4'hC, 0, "R9 legacy ch offset0 reads zero");
    wr(4'hD, 4'h8);
    check("R9 clear on legacy ch", int'(gate_off_o[3]), 1);
    check("R9 ch1 err untouched", int'(err_o[1]), 0);
  endtask

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stage();
    t_update();
    t_clear();
    t_range();
    t_direct();
    t_legacy();
    t_isolate();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule